// File: doc/BRIEF.md
# Grouped Event Status and Interrupt Steering Hub

This block gathers single-cycle event pulses from up to 96 peripheral sources and keeps each one as a sticky bit. The bits are held in three 32-bit status words. Software acknowledges an event by writing a 1 to its bit. Writing a 0 to a bit has no effect on it.

The same 96 status bits feed three interrupt outputs. Each output has its own set of three enable words, one for each status word, so software can steer any event to any mix of outputs. Each output also has a read-only vector word. It gives the lowest-numbered event that is both pending and enabled for that output, so a handler can find its source in a single read.

The register port is a plain 32-bit bus with a single-cycle write strobe and a combinational read path. There is no handshake on it.

Top module: `evgrp_irq_hub`

## Requirements
- R1: A pulse on `evt_pulse[n]` sets bit n%32 of the status word at offset 4·(n/32). The new bit is visible on a read in the cycle after the pulse.
- R2: A status bit that is set stays set, for any number of cycles, until it is acknowledged.
- R3: A write to a status word clears each bit where the write data is 1. Bits where the write data is 0 keep their value.
- R4: If a pulse and an acknowledgement reach the same status bit in the same cycle, the bit ends up set.
- R5: Enable word L of group g sits at offset 0x10·(g+1) + 4·L, for g and L in 0..2. Each is an ordinary read/write register.
- R6: `irq_out[g]` is high exactly when some status bit is set whose matching enable bit in group g is also 1. Index 0 is the highest-priority processor line and index 2 the lowest.
- R7: The vector word of group g sits at offset 0x40 + 4·g. Its bits 6:0 hold the lowest event number that is both set and enabled in group g. Bit 31 is 1, and bits 6:0 are 0, when no such event exists. Writes to a vector word do nothing.
- R8: A read of any offset outside the status, enable and vector words returns zero. A write there changes no register.
- R9: Reset clears all status and enable bits. Afterwards every interrupt output is low and every vector word reads 0x8000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 96 | One-cycle event pulses, bit n is event n |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 3 | Level interrupt per enable group |

## Verification
A lost or invented status bit shows up in the very next cycle, in two places: the status word reads back wrong, and so does the vector word of every group that enables that bit. A wrong enable bit or decode leaves the interrupt output and the vector word for that group disagreeing with a model built from the requirements. This also appears as soon as the write has settled. A priority encoder that chose the wrong index would only show when two or more bits are pending at once. The bench therefore stacks events across a word boundary and at the top and bottom of the event range.

// File: rtl/evgrp_pkg.sv
package evgrp_pkg;
  // Register layout, one function per register kind.
  function automatic int stat_off(input int bank);
    return 4 * bank;
  endfunction

  function automatic int mask_off(input int grp, input int bank);
    return 16 * (grp + 1) + 4 * bank;
  endfunction

  function automatic int vec_off(input int grp);
    return 64 + 4 * grp;
  endfunction
endpackage

// File: rtl/evgrp_status_bank.sv
module evgrp_status_bank #(
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] evt,
  input  logic [BW-1:0] clr,
  output logic [BW-1:0] stat_q
);
  // Clear first, then set: a fresh event beats an acknowledge.
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | evt;
  end
endmodule

// File: rtl/evgrp_mask_group.sv
module evgrp_mask_group #(
  parameter int NBANK = 3,
  parameter int BW    = 32,
  localparam int NEVT = NBANK * BW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] wen,
  input  logic [BW-1:0]    wdata,
  input  logic [NEVT-1:0]  stat,
  output logic [NEVT-1:0]  mask_q,
  output logic [NEVT-1:0]  live,
  output logic             irq
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)      mask_q[b*BW +: BW] <= '0;
      else if (wen[b]) mask_q[b*BW +: BW] <= wdata;
    end
  end

  assign live = stat & mask_q;
  assign irq  = |live;
endmodule

// File: rtl/evgrp_lowest_enc.sv
module evgrp_lowest_enc #(
  parameter int N  = 96,
  parameter int IW = 7
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          none
);
  // Walk downwards so the lowest set bit is the last one assigned.
  always_comb begin
    idx  = '0;
    none = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx  = IW'(i);
        none = 1'b0;
      end
    end
  end
endmodule

// File: rtl/evgrp_irq_hub.sv
module evgrp_irq_hub #(
  parameter int NBANK = 3,
  parameter int BW    = 32,
  parameter int NGRP  = 3,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NBANK*BW-1:0] evt_pulse,
  input  logic [AW-1:0]       reg_addr,
  input  logic                reg_wen,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic [NGRP-1:0]     irq_out
);
  import evgrp_pkg::*;

  localparam int NEVT = NBANK * BW;
  localparam int EVW  = $clog2(NEVT);
  localparam int PADW = DW - 1 - EVW;

  // Named internal events, brought out for the checker.
  logic [NEVT-1:0]             stat_all;
  logic [NEVT-1:0]             clr_all;
  logic [NBANK-1:0]            stat_hit;
  logic [NGRP-1:0][NBANK-1:0]  mask_hit;
  logic [NGRP-1:0][NEVT-1:0]   mask_all;
  logic [NGRP-1:0][NEVT-1:0]   live_all;
  logic [NGRP-1:0][EVW-1:0]    vec_idx;
  logic [NGRP-1:0]             vec_none;

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      stat_hit[b] = (int'(reg_addr) == stat_off(b));
      for (int g = 0; g < NGRP; g++)
        mask_hit[g][b] = (int'(reg_addr) == mask_off(g, b));
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_stat
    assign clr_all[b*BW +: BW] = (reg_wen && stat_hit[b]) ? reg_wdata[BW-1:0] : '0;

    evgrp_status_bank #(.BW(BW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_pulse[b*BW +: BW]),
      .clr    (clr_all[b*BW +: BW]),
      .stat_q (stat_all[b*BW +: BW])
    );
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    evgrp_mask_group #(.NBANK(NBANK), .BW(BW)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wen    (mask_hit[g] & {NBANK{reg_wen}}),
      .wdata  (reg_wdata[BW-1:0]),
      .stat   (stat_all),
      .mask_q (mask_all[g]),
      .live   (live_all[g]),
      .irq    (irq_out[g])
    );

    evgrp_lowest_enc #(.N(NEVT), .IW(EVW)) u_enc (
      .vec  (live_all[g]),
      .idx  (vec_idx[g]),
      .none (vec_none[g])
    );
  end

  // Read mux: every unmapped offset falls through to zero.
  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (stat_hit[b]) reg_rdata = DW'(stat_all[b*BW +: BW]);
      for (int g = 0; g < NGRP; g++)
        if (mask_hit[g][b]) reg_rdata = DW'(mask_all[g][b*BW +: BW]);
    end
    for (int g = 0; g < NGRP; g++)
      if (int'(reg_addr) == vec_off(g))
        reg_rdata = {vec_none[g], {PADW{1'b0}}, vec_idx[g]};
  end
endmodule

// File: rtl/evgrp_irq_hub_chk.sv
module evgrp_irq_hub_chk #(
  parameter int NEVT = 96,
  parameter int NGRP = 3,
  parameter int EVW  = 7
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NEVT-1:0]           evt_pulse,
  input logic [NEVT-1:0]           clr_vec,
  input logic [NEVT-1:0]           stat_q,
  input logic [NGRP-1:0]           irq_out,
  input logic [NGRP-1:0]           vec_none,
  input logic [NGRP-1:0][EVW-1:0]  vec_idx
);
  // R1 / R4: every pulsed bit is set one cycle later, acknowledged or not.
  p_pulse_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse)));

  // R2 / R3: a set bit that was not acknowledged is still set.
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != '0) |=>
      ((stat_q & $past(stat_q) & ~$past(clr_vec)) == ($past(stat_q) & ~$past(clr_vec))));

  // R3: no bit appears without a pulse.
  p_no_phantom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_q & ~$past(stat_q) & ~$past(evt_pulse)) == '0));

  for (genvar g = 0; g < NGRP; g++) begin : g_out
    // R6 / R7: the output line and the encoder must agree on "pending".
    p_irq_vs_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[g] != vec_none[g]);
    // R7: a reported index is inside the event range and names a set bit.
    p_vec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_none[g] |-> ((int'(vec_idx[g]) < NEVT) && stat_q[vec_idx[g]]));
  end
endmodule

bind evgrp_irq_hub evgrp_irq_hub_chk #(.NEVT(NEVT), .NGRP(NGRP), .EVW(EVW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_pulse (evt_pulse),
  .clr_vec   (clr_all),
  .stat_q    (stat_all),
  .irq_out   (irq_out),
  .vec_none  (vec_none),
  .vec_idx   (vec_idx)
);

// File: tb/test_evgrp_irq_hub.sv
module test_evgrp_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] evt_pulse = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  evgrp_irq_hub i_evgrp_irq_hub (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_addr(reg_addr),
    .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  localparam logic [31:0] NONE = 32'h8000_0000;
  // Row: {req, op, addr, data, expected}; op 0 pulse event, 1 write, 2 read, 3 irq.
  localparam int NV = 34;
  localparam logic [77:0] TBL [NV] = '{
    {4'd9, 2'd2, 8'h00, 32'h0,          32'h0},        // R9 status empty
    {4'd9, 2'd2, 8'h40, 32'h0,          NONE},         // R9 vector none
    {4'd9, 2'd3, 8'h00, 32'h0,          32'h0},        // R9 irq low
    {4'd1, 2'd0, 8'h00, 32'd5,          32'h0},
    {4'd1, 2'd2, 8'h00, 32'h0,          32'h0000_0020},// R1 event 5
    {4'd1, 2'd0, 8'h00, 32'd40,         32'h0},
    {4'd1, 2'd2, 8'h04, 32'h0,          32'h0000_0100},// R1 event 40
    {4'd1, 2'd0, 8'h00, 32'd95,         32'h0},
    {4'd1, 2'd2, 8'h08, 32'h0,          32'h8000_0000},// R1 event 95
    {4'd6, 2'd3, 8'h00, 32'h0,          32'h0},        // R6 all masked
    {4'd5, 2'd1, 8'h14, 32'h0000_0100,  32'h0},
    {4'd6, 2'd3, 8'h00, 32'h0,          32'h1},        // R6 group 0 only
    {4'd7, 2'd2, 8'h40, 32'h0,          32'd40},       // R7
    {4'd5, 2'd1, 8'h10, 32'h0000_0020,  32'h0},
    {4'd7, 2'd2, 8'h40, 32'h0,          32'd5},        // R7 lowest wins
    {4'd5, 2'd1, 8'h38, 32'h8000_0000,  32'h0},
    {4'd6, 2'd3, 8'h00, 32'h0,          32'h5},        // R6 groups 0 and 2
    {4'd7, 2'd2, 8'h48, 32'h0,          32'd95},       // R7
    {4'd7, 2'd2, 8'h44, 32'h0,          NONE},         // R7 group 1 idle
    {4'd5, 2'd2, 8'h14, 32'h0,          32'h0000_0100},// R5 readback
    {4'd5, 2'd2, 8'h38, 32'h0,          32'h8000_0000},// R5 readback
    {4'd3, 2'd1, 8'h00, 32'h0,          32'h0},
    {4'd3, 2'd2, 8'h00, 32'h0,          32'h0000_0020},// R3 zero write keeps
    {4'd3, 2'd1, 8'h00, 32'h0000_0020,  32'h0},
    {4'd3, 2'd2, 8'h00, 32'h0,          32'h0},        // R3 cleared
    {4'd7, 2'd2, 8'h40, 32'h0,          32'd40},       // R7 next pending
    {4'd3, 2'd1, 8'h04, 32'h0000_0100,  32'h0},
    {4'd6, 2'd3, 8'h00, 32'h0,          32'h4},        // R6
    {4'd8, 2'd1, 8'h0C, 32'hFFFF_FFFF,  32'h0},
    {4'd8, 2'd2, 8'h0C, 32'h0,          32'h0},        // R8 hole reads 0
    {4'd8, 2'd2, 8'h08, 32'h0,          32'h8000_0000},// R8 status untouched
    {4'd7, 2'd1, 8'h40, 32'h0000_0005,  32'h0},
    {4'd7, 2'd2, 8'h40, 32'h0,          NONE},         // R7 vector read-only
    {4'd8, 2'd2, 8'h4C, 32'h0,          32'h0}         // R8 hole reads 0
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse(input int n);
    @(negedge clk) evt_pulse = '0; evt_pulse[n] = 1'b1;
    @(negedge clk) evt_pulse = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk) reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk) reg_wen = 1'b0;
  endtask

  task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk) reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic irq(input int req, input logic [2:0] exp);
    @(negedge clk);
    #1 check(req, {29'd0, irq_out}, {29'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      case (TBL[i][73:72])
        2'd0: pulse(int'(TBL[i][63:32]));
        2'd1: wr(TBL[i][71:64], TBL[i][63:32]);
        2'd2: rd(int'(TBL[i][77:74]), TBL[i][71:64], TBL[i][31:0]);
        default: irq(int'(TBL[i][77:74]), TBL[i][2:0]);
      endcase
    end
    wr(8'h08, 32'h8000_0000);
    irq(6, 3'b000);                          // R6 everything acknowledged

    // R2: held across many idle cycles
    pulse(10);
    repeat (20) @(negedge clk);
    rd(2, 8'h00, 32'h0000_0400);

    // R4: pulse and acknowledge on the same bit in one cycle
    @(negedge clk) evt_pulse[10] = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h400; reg_wen = 1'b1;
    @(negedge clk) evt_pulse = '0; reg_wen = 1'b0;
    rd(4, 8'h00, 32'h0000_0400);

    // R6: one event steered to all three groups
    wr(8'h10, 32'h400); wr(8'h20, 32'h400); wr(8'h30, 32'h400);
    irq(6, 3'b111);
    wr(8'h20, 32'h0);
    irq(6, 3'b101);

    // R7: word boundary and range ends
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h00, 32'h400);
    pulse(32);
    rd(7, 8'h44, 32'd32);
    pulse(31);
    rd(7, 8'h44, 32'd31);
    pulse(0);
    rd(7, 8'h44, 32'd0);
    rd(5, 8'h24, 32'hFFFF_FFFF);

    // R9: reset mid-run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rd(9, 8'h00, 32'h0);
    rd(9, 8'h24, 32'h0);
    rd(9, 8'h44, NONE);
    irq(9, 3'b000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule